// File: doc/BRIEF.md
# Step-Issued Non-Restoring Integer Divider

This block divides a 32-bit or a 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder, treating the operands as either two's-complement or unsigned values. It uses the non-restoring method and performs exactly one step on each clock in which the surrounding sequencer issues a step. Every piece of intermediate state lives in registers that change only when a step is issued, so a loop controller can stop the sequence at any cycle boundary (for example to service an interrupt) and resume it later without losing work.

A divide is 19 steps long. The start strobe is the first step: it captures the operands, records the operand signs and stores their magnitudes. Seventeen shift-and-add/subtract steps follow, and a last step corrects the remainder and applies the signs. A step is issued in a cycle where step-enable is high and hold is low. The results and a divide-by-zero flag stay on the outputs until the next start.

Top module: `sdiv_unit`

## Requirements
- R1: While reset is high and after it is released, busy, done and the divide-by-zero flag are 0, and quotient and remainder are 0.
- R2: A cycle with start high begins a divide on any state. After that clock edge busy is 1 and done is 0.
- R3: After start, done rises and busy falls on the clock edge of the 18th issued step, which makes 19 steps in all. A step is issued in a cycle where step_en_i is 1 and hold_i is 0.
- R4: In a busy cycle with step_en_i low, the divide does not progress: busy, done, the step count and the outputs keep their values, with no limit on the length of the pause.
- R5: hold_i high suspends the divide even when step_en_i is high. It has the same effect as step_en_i low.
- R6: With signed_i=0 and wide_i=1, the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor, both taken as unsigned numbers. This holds whenever the quotient fits in 16 bits.
- R7: With signed_i=1 and wide_i=1, the quotient is truncated toward zero. Its sign is the XOR of the operand signs and the remainder carries the dividend's sign. This holds whenever the quotient fits in the signed 16-bit range.
- R8: With wide_i=0, only dividend_i[15:0] is used. It is sign-extended when signed_i=1 and zero-extended when signed_i=0, and the results then follow R6 or R7. Bits 31:16 have no effect.
- R9: A zero divisor still completes in the R3 step count. div_zero_o reads 1 together with done; quotient and remainder are then unspecified. A nonzero divisor leaves div_zero_o at 0.
- R10: A start during a busy divide abandons it. The new divide then runs the full R3 sequence on the new operands.
- R11: After done, the outputs and done hold while start stays low, whatever step_en_i, hold_i and the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a divide; is the first (setup) step |
| step_en_i | input | 1 | Issues one step when hold_i is low |
| hold_i | input | 1 | Suspends stepping while high |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| wide_i | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| dividend_i | input | 32 | Dividend, sampled on start |
| divisor_i | input | 16 | Divisor, sampled on start |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | Result valid; held until next start |
| div_zero_o | output | 1 | Divisor was zero (valid with done) |
| quotient_o | output | 16 | Quotient |
| remainder_o | output | 16 | Remainder |

## Verification
Unsigned 32-bit operands are built from a chosen quotient, divisor and remainder. Signed 32-bit operands are built the same way, with all four sign combinations. Together these show that the per-step add/subtract choice and the final remainder correction are right, and that each sign is applied to the correct result. The 16-bit cases carry random upper dividend bits, which shows that the narrow mode ignores them and extends the low half correctly. The corner cases are the most negative 16-bit dividend, divisors of 1 and -1, a zero dividend, a dividend smaller than the divisor, the largest unsigned quotient and a zero divisor; each of these hits an extreme of the magnitude or sign handling. Random pauses and holds are mixed into every run, and one divide is restarted while busy, so any step taken or lost while the divider is suspended shows up as a shift in when done appears.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int DIVIDEND_W = 32;
    localparam int DIVISOR_W  = 16;
    localparam int ITERS      = DIVIDEND_W - DIVISOR_W + 1;   // quotient bits developed
    localparam int HEAD_W     = DIVIDEND_W - ITERS;           // dividend bits preloaded into the partial remainder
    localparam int PART_W     = DIVISOR_W + 3;                // partial remainder with sign and headroom
    localparam int CNT_W      = $clog2(ITERS + 2);
    localparam int TOTAL_ADV  = ITERS + 1;                    // issued steps after the start step

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ITER = 2'd1,
        PH_FIX  = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t                phase;
        logic [PART_W-1:0]     part;
        logic [ITERS-1:0]      acc;
        logic [DIVISOR_W-1:0]  dmag;
        logic [CNT_W-1:0]      cnt;
        logic                  neg_q;
        logic                  neg_r;
        logic                  dz;
    } div_state_t;

    function automatic logic [DIVIDEND_W-1:0] cneg_wide(input logic [DIVIDEND_W-1:0] v, input logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [DIVISOR_W-1:0] cneg_narrow(input logic [DIVISOR_W-1:0] v, input logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
(
    input  logic                  signed_i,
    input  logic                  wide_i,
    input  logic [DIVIDEND_W-1:0] dividend_i,
    input  logic [DIVISOR_W-1:0]  divisor_i,
    output logic [DIVIDEND_W-1:0] nmag_o,
    output logic [DIVISOR_W-1:0]  dmag_o,
    output logic                  neg_q_o,
    output logic                  neg_r_o,
    output logic                  dz_o
);
    localparam int EXT_W = DIVIDEND_W - DIVISOR_W;

    logic [DIVIDEND_W-1:0] ext;
    logic                  n_neg;
    logic                  d_neg;

    always_comb begin
        if (wide_i) begin
            ext = dividend_i;
        end else begin
            ext = {{EXT_W{signed_i & dividend_i[DIVISOR_W-1]}}, dividend_i[DIVISOR_W-1:0]};
        end
        n_neg   = signed_i & ext[DIVIDEND_W-1];
        d_neg   = signed_i & divisor_i[DIVISOR_W-1];
        nmag_o  = cneg_wide(ext, n_neg);
        dmag_o  = cneg_narrow(divisor_i, d_neg);
        neg_q_o = n_neg ^ d_neg;
        neg_r_o = n_neg;
        dz_o    = (divisor_i == '0);
    end
endmodule

// File: rtl/sdiv_iter.sv
module sdiv_iter
    import sdiv_pkg::*;
(
    input  logic [PART_W-1:0]    part_i,
    input  logic [ITERS-1:0]     acc_i,
    input  logic [DIVISOR_W-1:0] dmag_i,
    output logic [PART_W-1:0]    part_o,
    output logic [ITERS-1:0]     acc_o
);
    logic [PART_W-1:0] shifted;
    logic [PART_W-1:0] dext;

    always_comb begin
        shifted = {part_i[PART_W-2:0], acc_i[ITERS-1]};
        dext    = {{(PART_W-DIVISOR_W){1'b0}}, dmag_i};
        // negative remainder: add back; non-negative: subtract
        part_o  = part_i[PART_W-1] ? (shifted + dext) : (shifted - dext);
        acc_o   = {acc_i[ITERS-2:0], ~part_o[PART_W-1]};
    end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup
    import sdiv_pkg::*;
(
    input  logic                 part_neg_i,
    input  logic [DIVISOR_W-1:0] part_low_i,
    input  logic [DIVISOR_W-1:0] qmag_i,
    input  logic [DIVISOR_W-1:0] dmag_i,
    input  logic                 neg_q_i,
    input  logic                 neg_r_i,
    output logic [DIVISOR_W-1:0] quo_o,
    output logic [DIVISOR_W-1:0] rem_o
);
    logic [DIVISOR_W-1:0] rmag;

    always_comb begin
        rmag  = part_neg_i ? (part_low_i + dmag_i) : part_low_i;
        quo_o = cneg_narrow(qmag_i, neg_q_i);
        rem_o = cneg_narrow(rmag, neg_r_i);
    end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
    import sdiv_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  start_i,
    input  logic                  step_en_i,
    input  logic                  hold_i,
    input  logic                  signed_i,
    input  logic                  wide_i,
    input  logic [DIVIDEND_W-1:0] dividend_i,
    input  logic [DIVISOR_W-1:0]  divisor_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  div_zero_o,
    output logic [DIVISOR_W-1:0]  quotient_o,
    output logic [DIVISOR_W-1:0]  remainder_o
);
    localparam logic [CNT_W-1:0] ITER_LAST = CNT_W'(ITERS - 1);

    div_state_t            st_q;
    logic                  done_q;
    logic                  dz_q;
    logic [DIVISOR_W-1:0]  quo_q;
    logic [DIVISOR_W-1:0]  rem_q;
    logic                  advance;

    logic [DIVIDEND_W-1:0] p_nmag;
    logic [DIVISOR_W-1:0]  p_dmag;
    logic                  p_neg_q;
    logic                  p_neg_r;
    logic                  p_dz;

    logic [PART_W-1:0]     it_part;
    logic [ITERS-1:0]      it_acc;

    logic [DIVISOR_W-1:0]  fx_quo;
    logic [DIVISOR_W-1:0]  fx_rem;

    logic [CNT_W-1:0]      step_cnt;

    assign advance  = step_en_i & ~hold_i;
    assign step_cnt = st_q.cnt;

    sdiv_prep u_prep (
        .signed_i   (signed_i),
        .wide_i     (wide_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .nmag_o     (p_nmag),
        .dmag_o     (p_dmag),
        .neg_q_o    (p_neg_q),
        .neg_r_o    (p_neg_r),
        .dz_o       (p_dz)
    );

    sdiv_iter u_iter (
        .part_i (st_q.part),
        .acc_i  (st_q.acc),
        .dmag_i (st_q.dmag),
        .part_o (it_part),
        .acc_o  (it_acc)
    );

    sdiv_fixup u_fix (
        .part_neg_i (st_q.part[PART_W-1]),
        .part_low_i (st_q.part[DIVISOR_W-1:0]),
        .qmag_i     (st_q.acc[DIVISOR_W-1:0]),
        .dmag_i     (st_q.dmag),
        .neg_q_i    (st_q.neg_q),
        .neg_r_i    (st_q.neg_r),
        .quo_o      (fx_quo),
        .rem_o      (fx_rem)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= '0;
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else if (start_i) begin
            st_q.phase <= PH_ITER;
            st_q.part  <= {{(PART_W-HEAD_W){1'b0}}, p_nmag[DIVIDEND_W-1:ITERS]};
            st_q.acc   <= p_nmag[ITERS-1:0];
            st_q.dmag  <= p_dmag;
            st_q.cnt   <= '0;
            st_q.neg_q <= p_neg_q;
            st_q.neg_r <= p_neg_r;
            st_q.dz    <= p_dz;
            done_q     <= 1'b0;
            dz_q       <= 1'b0;
        end else if (advance) begin
            case (st_q.phase)
                PH_ITER: begin
                    st_q.part <= it_part;
                    st_q.acc  <= it_acc;
                    st_q.cnt  <= st_q.cnt + 1'b1;
                    if (st_q.cnt == ITER_LAST) begin
                        st_q.phase <= PH_FIX;
                    end
                end
                PH_FIX: begin
                    st_q.phase <= PH_IDLE;
                    quo_q      <= fx_quo;
                    rem_q      <= fx_rem;
                    dz_q       <= st_q.dz;
                    done_q     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o      = (st_q.phase != PH_IDLE);
    assign done_o      = done_q;
    assign div_zero_o  = dz_q;
    assign quotient_o  = quo_q;
    assign remainder_o = rem_q;

endmodule

// File: rtl/sdiv_unit_chk.sv
module sdiv_unit_chk
    import sdiv_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 step_en,
    input logic                 hold,
    input logic                 busy,
    input logic                 done,
    input logic                 dz,
    input logic [DIVISOR_W-1:0] quo,
    input logic [DIVISOR_W-1:0] rem,
    input logic [CNT_W-1:0]     step_cnt
);
    localparam int WIN_W = $clog2(TOTAL_ADV + 2);

    logic [WIN_W-1:0] issued;
    logic             adv;

    assign adv = step_en & ~hold;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            issued <= '0;
        end else if (busy && adv) begin
            issued <= issued + 1'b1;
        end
    end

    AST_START_BUSY:   assert property (@(posedge clk) disable iff (rst) start |=> busy && !done);                                // R2
    AST_NOT_BOTH:     assert property (@(posedge clk) disable iff (rst) !(busy && done));                                        // R3
    AST_DONE_COUNT:   assert property (@(posedge clk) disable iff (rst) $rose(done) |-> issued == WIN_W'(TOTAL_ADV));            // R3
    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst) busy && !start && !step_en |=> $stable(step_cnt) && busy); // R4
    AST_HOLD_WINS:    assert property (@(posedge clk) disable iff (rst) busy && !start && hold |=> $stable(step_cnt) && !done);    // R5
    AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (rst) dz |-> done);                                            // R9
    AST_RESULT_HELD:  assert property (@(posedge clk) disable iff (rst) done && !start |=> done && $stable(quo) && $stable(rem)); // R11

endmodule

bind sdiv_unit sdiv_unit_chk u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .start    (start_i),
    .step_en  (step_en_i),
    .hold     (hold_i),
    .busy     (busy_o),
    .done     (done_o),
    .dz       (div_zero_o),
    .quo      (quotient_o),
    .rem      (remainder_o),
    .step_cnt (step_cnt)
);

// File: tb/sdiv_unit_bench.sv
`timescale 1ns/1ps
module sdiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic        hold = 1'b0;
    logic        sgn = 1'b0;
    logic        wide = 1'b1;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, dz;
    logic [15:0] quo, rem;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic compare_on = 1'b0;

    always #2.5 clk = ~clk;

    sdiv_unit u_sdiv_unit (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start),
        .step_en_i   (step_en),
        .hold_i      (hold),
        .signed_i    (sgn),
        .wide_i      (wide),
        .dividend_i  (dividend),
        .divisor_i   (divisor),
        .busy_o      (busy),
        .done_o      (done),
        .div_zero_o  (dz),
        .quotient_o  (quo),
        .remainder_o (rem)
    );

    // behavioural reference
    logic        m_busy = 1'b0, m_done = 1'b0, m_dz = 1'b0, m_known = 1'b0;
    logic [15:0] m_q = '0, m_r = '0;
    int          m_steps = 0;
    string       m_tag = "R1";
    string       m_mode = "R6";

    always @(posedge clk) begin
        longint nn, dd, qq, rr;
        if (rst) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_dz <= 1'b0; m_known <= 1'b0;
            m_q <= '0; m_r <= '0; m_steps <= 0; m_tag <= "R1";
        end else if (start) begin
            m_tag   <= m_busy ? "R10" : "R2";
            m_busy  <= 1'b1;
            m_done  <= 1'b0;
            m_dz    <= 1'b0;
            m_steps <= 0;
            if (wide) nn = sgn ? longint'($signed(dividend)) : longint'(dividend);
            else      nn = sgn ? longint'($signed(dividend[15:0])) : longint'(dividend[15:0]);
            dd = sgn ? longint'($signed(divisor)) : longint'(divisor);
            m_mode <= !wide ? "R8" : (sgn ? "R7" : "R6");
            if (dd == 0) begin
                m_known <= 1'b0;
            end else begin
                qq = nn / dd;
                rr = nn % dd;
                m_q <= qq[15:0];
                m_r <= rr[15:0];
                m_known <= 1'b1;
            end
        end else if (m_busy && step_en && !hold) begin
            m_tag   <= "R3";
            m_steps <= m_steps + 1;
            if (m_steps == 17) begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
                m_dz   <= !m_known;
            end
        end else begin
            m_tag <= m_busy ? (hold ? "R5" : "R4") : "R11";
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on) begin
            chk(m_tag, "busy", 32'(busy), 32'(m_busy));
            chk(m_tag, "done", 32'(done), 32'(m_done));
            chk("R9", "div_zero", 32'(dz), 32'(m_done & m_dz));
            if (m_done && m_known) begin
                chk(m_mode, "quotient", 32'(quo), 32'(m_q));
                chk(m_mode, "remainder", 32'(rem), 32'(m_r));
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    task automatic launch(input logic [31:0] n, input logic [15:0] d, input logic s, input logic w);
        @(negedge clk);
        start = 1'b1; dividend = n; divisor = d; sgn = s; wide = w;
        step_en = $urandom_range(0, 1); hold = $urandom_range(0, 1);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step_until_done(input int pause_pct);
        for (int k = 0; k < 2000 && !done; k++) begin
            step_en = ($urandom_range(0, 99) >= pause_pct);
            hold    = ($urandom_range(0, 99) < pause_pct / 2);
            @(negedge clk);
        end
        // idle with noisy inputs: results must hold (R11)
        for (int k = 0; k < 3; k++) begin
            step_en  = $urandom_range(0, 1);
            hold     = $urandom_range(0, 1);
            dividend = $urandom;
            divisor  = 16'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic run_div(input logic [31:0] n, input logic [15:0] d, input logic s, input logic w, input int pause_pct);
        launch(n, d, s, w);
        step_until_done(pause_pct);
    endtask

    initial begin
        longint dm, qm, rm, mag;
        logic   sn, sd;
        logic [31:0] nv;
        logic [15:0] dv;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "div_zero", 32'(dz), 0);
        chk("R1", "quotient", 32'(quo), 0);
        chk("R1", "remainder", 32'(rem), 0);
        rst = 1'b0;
        @(negedge clk);
        compare_on = 1'b1;

        // directed corners
        run_div(32'd100000, 16'd7, 1'b0, 1'b1, 0);             // R6
        run_div(32'hFFFE_FFFF, 16'hFFFF, 1'b0, 1'b1, 30);      // R6 largest quotient
        run_div(32'd5, 16'd7, 1'b0, 1'b1, 0);                  // R6 quotient 0
        run_div(32'd0, 16'd9, 1'b1, 1'b1, 20);                 // R7 zero dividend
        run_div(32'hFFFF_8000, 16'd1, 1'b1, 1'b1, 20);         // R7 -32768 / 1
        run_div(32'd32767, 16'hFFFF, 1'b1, 1'b1, 20);          // R7 divisor -1
        run_div(32'hFFFF_8001, 16'hFFFF, 1'b1, 1'b1, 20);      // R7 -32767 / -1
        run_div(32'hABCD_8000, 16'd1, 1'b1, 1'b0, 40);         // R8 most negative 16-bit / 1
        run_div(32'h1234_8000, 16'hFFFE, 1'b1, 1'b0, 40);      // R8 -32768 / -2
        run_div(32'h5555_8000, 16'd3, 1'b1, 1'b0, 40);         // R8 -32768 / 3
        run_div(32'hDEAD_FFFF, 16'd1, 1'b0, 1'b0, 40);         // R8 65535 / 1 unsigned
        run_div(32'd1234, 16'd0, 1'b0, 1'b1, 30);              // R9
        run_div(32'hFFFF_FF00, 16'd0, 1'b1, 1'b0, 30);         // R9

        // R4: long pause mid-divide
        launch(32'd987654, 16'd321, 1'b0, 1'b1);
        step_en = 1'b1; hold = 1'b0;
        repeat (6) @(negedge clk);
        step_en = 1'b0;
        repeat (40) @(negedge clk);
        step_until_done(0);

        // R5: hold asserted with step_en high
        launch(32'd77777, 16'd13, 1'b0, 1'b1);
        step_en = 1'b1; hold = 1'b1;
        repeat (25) @(negedge clk);
        hold = 1'b0;
        step_until_done(0);

        // R10: restart while busy
        launch(32'd55555, 16'd11, 1'b0, 1'b1);
        step_en = 1'b1; hold = 1'b0;
        repeat (9) @(negedge clk);
        launch(32'hFFFF_F000, 16'd100, 1'b1, 1'b1);
        step_until_done(25);

        // random unsigned wide, R6
        for (int i = 0; i < 40; i++) begin
            dm = longint'($urandom_range(1, 65535));
            qm = longint'($urandom_range(0, 65535));
            rm = longint'($urandom) % dm;
            mag = qm * dm + rm;
            run_div(mag[31:0], dm[15:0], 1'b0, 1'b1, 35);
        end
        // random signed wide, R7
        for (int i = 0; i < 40; i++) begin
            dm = longint'($urandom_range(1, 32767));
            qm = longint'($urandom_range(0, 32767));
            rm = longint'($urandom) % dm;
            mag = qm * dm + rm;
            sn = 1'($urandom_range(0, 1));
            sd = 1'($urandom_range(0, 1));
            nv = sn ? (~mag[31:0] + 32'd1) : mag[31:0];
            dv = sd ? (~dm[15:0] + 16'd1) : dm[15:0];
            run_div(nv, dv, 1'b1, 1'b1, 35);
        end
        // random 16-bit, R8
        for (int i = 0; i < 40; i++) begin
            nv = $urandom;
            dv = 16'($urandom_range(1, 65535));
            sn = 1'(i % 2);
            if (sn && nv[15:0] == 16'h8000 && dv == 16'hFFFF) dv = 16'd1;
            run_div(nv, dv, sn, 1'b0, 35);
        end

        summary();
    end

endmodule